// File: doc/BRIEF.md
# Four-Input Look-Up Table Logic Element

This block is a single configurable logic element of the kind tiled across a programmable fabric. A bank of sixteen loadable storage cells holds the truth table of any Boolean function of four variables. The four data inputs pick one cell through a binary tree of 2:1 multiplexers. The selected bit feeds a D flip-flop. A programmable output mode bit then passes either that combinational bit or the flip-flop's value to the single output.

Configuration is loaded serially over a one-bit chain while a configuration-enable input is held high. The chain holds seventeen bits: the sixteen truth-table cells and the output mode bit. In normal operation the enable is low, the configuration stays frozen, and the element behaves as the programmed function, with or without a register stage.

All pins are plain level signals. The data path has no flow control: the function is evaluated on every cycle, and the data inputs cannot be stalled. The block therefore has no valid/ready interface and no back-pressure rules.

Top module: `lut_logic_element`

## Requirements
- R1: With the mode bit 0 (combinational), `elem_out` equals the truth-table cell selected by the current `data_in`, within the same cycle. Any of the 65,536 possible 16-bit tables can be loaded and realised.
- R2: The cell index is the binary value of `data_in`, with `data_in[0]` as the least significant bit. For example, `data_in = 4'b0010` selects cell 2.
- R3: On every rising clock edge with `cfg_en` high, the chain shifts in `cfg_din`. After exactly 17 such shifts, the first bit shifted in is the mode bit. The next sixteen bits are cells 15, 14, … down to 0, with cell 0 shifted in last.
- R4: While `cfg_en` is low, the truth table and the mode bit do not change, whatever `cfg_din` does.
- R5: With the mode bit 1 (registered), `elem_out` is the flip-flop output. On each rising edge with `cfg_en` low, the flip-flop loads the cell selected by `data_in` at that edge.
- R6: On a rising edge with `cfg_en` high, the flip-flop keeps its value.
- R7: Driving `rst_n` low clears the flip-flop, all sixteen cells and the mode bit at once, without waiting for a clock edge. As a result `elem_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Element clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | High: shift the configuration chain and hold the flip-flop |
| cfg_din | input | 1 | Serial configuration data bit |
| data_in | input | 4 | Function inputs; bit 0 is the least significant index bit |
| elem_out | output | 1 | Element output, combinational or registered by the mode bit |

## Verification
The bench loads several truth tables and sweeps all sixteen input codes under each of them:
- A four-input AND with a single true cell catches tree-level and select-polarity faults.
- Parity, where every cell differs from its neighbours, catches any stuck or swapped leaf.
- A table with only cell 2 set tells the index order apart from a reversed one.

A registered-mode table is swept to confirm the one-cycle lag. It is then reloaded, so the flip-flop is seen holding while the chain shifts. Toggling `cfg_din` with `cfg_en` low, followed by a reset in the middle of a cycle, shows the frozen configuration and the immediate clear.

// File: rtl/le_pkg.sv
package le_pkg;
  localparam int LUT_INPUTS = 4;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int WIDTH = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic [WIDTH-1:0] bits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else if (shift_en) bits <= {bits[WIDTH-2:0], shift_in};
  end

  // R3: newest bit lands at position 0, older bits move up one place
  assert_shift_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(shift_en)) |->
      (bits[0] == $past(shift_in) && bits[WIDTH-1:1] == $past(bits[WIDTH-2:0])));

  // R4: configuration frozen without enable
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(shift_en)) |-> $stable(bits));
endmodule

// File: rtl/lut_tree.sv
module lut_tree #(
  parameter int N_IN = 4
) (
  input  logic [(1<<N_IN)-1:0] cells,
  input  logic [N_IN-1:0]      sel,
  output logic                 y
);
  localparam int CELLS = 1 << N_IN;
  localparam int NODES = 2 * CELLS - 1;

  logic [NODES-1:0] node;

  assign node[CELLS-1:0] = cells;

  // level l holds CELLS>>l nodes starting at 2*CELLS - 2*(CELLS>>l)
  for (genvar l = 1; l <= N_IN; l++) begin : g_level
    localparam int BASE_PREV = 2 * CELLS - 2 * (CELLS >> (l - 1));
    localparam int BASE_CUR  = 2 * CELLS - 2 * (CELLS >> l);
    for (genvar j = 0; j < (CELLS >> l); j++) begin : g_node
      assign node[BASE_CUR + j] = sel[l-1] ? node[BASE_PREV + 2*j + 1]
                                           : node[BASE_PREV + 2*j];
    end
  end

  assign y = node[NODES-1];
endmodule

// File: rtl/le_ff.sv
module le_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else if (!hold) q <= d;
  end

  // R6: no capture during configuration
  assert_ff_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hold)) |-> $stable(q));

  // R5: capture of the look-up result otherwise
  assert_ff_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(hold)) |-> (q == $past(d)));
endmodule

// File: rtl/lut_logic_element.sv
module lut_logic_element #(
  parameter int N_IN = le_pkg::LUT_INPUTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_din,
  input  logic [N_IN-1:0] data_in,
  output logic            elem_out
);
  import le_pkg::*;

  localparam int CELLS    = 1 << N_IN;
  localparam int CFG_BITS = CELLS + 1;

  logic [CFG_BITS-1:0] cfg_bits;
  logic [CELLS-1:0]    cells;
  out_mode_e           mode;
  logic                lut_y;
  logic                ff_q;

  cfg_chain #(.WIDTH(CFG_BITS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .shift_in (cfg_din),
    .bits     (cfg_bits)
  );

  assign cells = cfg_bits[CELLS-1:0];
  assign mode  = out_mode_e'(cfg_bits[CFG_BITS-1]);

  lut_tree #(.N_IN(N_IN)) u_tree (
    .cells (cells),
    .sel   (data_in),
    .y     (lut_y)
  );

  le_ff u_ff (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (cfg_en),
    .d     (lut_y),
    .q     (ff_q)
  );

  always_comb begin
    case (mode)
      OUT_REG: elem_out = ff_q;
      default: elem_out = lut_y;
    endcase
  end

  // R1 / R2: tree output is the cell addressed by data_in
  assert_tree_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lut_y == cells[data_in]);

  // R5: registered mode shows the previous cycle's look-up result
  assert_reg_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_en) && mode == OUT_REG) |-> (elem_out == $past(lut_y)));

  // R7: while held in reset the output reads zero
  assert_reset_out_R7: assert property (@(posedge clk)
    ($past(!rst_n) && !rst_n) |-> (elem_out == 1'b0));
endmodule

// File: tb/lut_logic_element_test.sv
module lut_logic_element_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic [3:0] data_in = 4'd0;
  logic       elem_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state: oldest bit at the front of the queue
  bit m_chain[$];
  bit m_q;

  always #4 clk = ~clk;

  lut_logic_element uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .data_in(data_in), .elem_out(elem_out)
  );

  function automatic bit model_cell(int idx);
    return m_chain[16 - idx];
  endfunction

  function automatic bit model_out(int idx);
    if (m_chain[0]) return m_q;
    return model_cell(idx);
  endfunction

  task automatic model_reset();
    m_chain.delete();
    for (int i = 0; i < 17; i++) m_chain.push_back(1'b0);
    m_q = 1'b0;
  endtask

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: elem_out=%0b expected %0b (data_in=%0d)", tag, act, exp, data_in);
    end
  endtask

  // one clock cycle: drive, compare mid-cycle, then advance the model at the edge
  task automatic cycle(string tag, bit en, bit din, int idx);
    @(negedge clk);
    cfg_en = en; cfg_din = din; data_in = idx[3:0];
    #1 check(tag, elem_out, model_out(idx));
    @(posedge clk);
    if (en) begin
      void'(m_chain.pop_front());
      m_chain.push_back(din);
    end else begin
      m_q = model_cell(idx);
    end
  endtask

  // R3: mode bit first, then cells 15 down to 0
  task automatic load(bit mode, bit [15:0] table_bits);
    cycle("R3", 1'b1, mode, 5);
    for (int k = 15; k >= 0; k--) cycle("R3 R6", 1'b1, table_bits[k], (k * 7) & 15);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 16; i++) cycle(tag, 1'b0, 1'b0, i);
    for (int i = 15; i >= 0; i--) cycle(tag, 1'b0, 1'b1, (i * 5) & 15);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    #21;
    check("R7 reset", elem_out, 1'b0);
    rst_n = 1'b1;

    // R1 / R2: AND of all four inputs, combinational
    load(1'b0, 16'h8000);
    sweep("R1 and4");
    // R1: parity
    load(1'b0, 16'h6996);
    sweep("R1 parity");
    // R2: only cell 2 set, true only when data_in[1] alone is high
    load(1'b0, 16'h0004);
    sweep("R2 index order");
    // R4: enable low, cfg_din toggling, table must be unchanged
    for (int i = 0; i < 16; i++) cycle("R4 frozen", 1'b0, i[0], i);

    // R5: registered mode
    load(1'b1, 16'hA5C3);
    sweep("R5 registered");
    // R6: reload while registered; flip-flop holds during the shifts
    load(1'b1, 16'h3C5A);
    sweep("R5 R6 reload");

    // R7: asynchronous reset in mid-cycle
    @(negedge clk);
    cfg_en = 1'b0; data_in = 4'd0;
    #2 rst_n = 1'b0;
    #1 model_reset();
    check("R7 async clear", elem_out, 1'b0);
    @(posedge clk); #1;
    check("R7 held", elem_out, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    sweep("R7 after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule